// File: doc/BRIEF.md
# Pin Controller with Interrupt Detection and Input Debounce

This block drives and samples a bank of general-purpose pins through a small 32-bit register bus. Each pin has an output data bit and an output-enable bit, and software can change single output bits without a read-modify-write by writing a one-hot pattern to a set address or a clear address. Pull-enable, pull-type and bypass bits are held in registers and passed straight to the pad ring, which lies outside this block.

Each input goes through a two-stage synchronizer. After that it can pass through an optional debounce filter. The filter samples the synchronized input on a tick from a shared 16-bit prescaler and changes only when two successive samples agree. The resulting signal feeds a per-pin interrupt detector. The detector is set per pin to level or edge mode, active-high/rising or active-low/falling polarity, and optional detection on both edges. Edge events stay latched until software writes a one to the interrupt clear address. The masked status and the single `irq` output hide pins whose mask bit is set.

The register bus is a plain control path with no stream data, so it has no valid/ready handshake. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `gpio_bank_top`

## Requirements
- R1: Storage registers read back what was written: output enable (0x08, 1 = drive), bypass (0x0C), pull enable (0x18), pull type (0x1C), interrupt enable (0x20), mask (0x2C), trigger (0x34), both-edge (0x38), polarity (0x3C) and debounce enable (0x40). The prescale register (0x44) keeps only bits 15:0. `pin_oe`, `pin_bypass`, `pin_pull_en` and `pin_pull_up` show the matching registers.
- R2: A write to 0x10 sets every output bit where the write data has a one. A write to 0x14 clears every such bit. Zero bits leave the bit unchanged. A write to 0x00 loads all bits, and `pin_out` follows the register.
- R3: Reading 0x04 returns `pin_in` after two clock edges of synchronization.
- R4: With trigger bit 0 (edge), a rising edge (polarity 0) or falling edge (polarity 1) of an enabled pin sets its raw status bit (read at 0x24). The bit stays set afterwards.
- R5: With a both-edge bit set, either edge of that edge-mode pin sets its raw bit, whatever its polarity bit.
- R6: With trigger bit 1 (level), the raw bit of an enabled pin equals the input XOR its polarity bit, one clock after the synchronized input.
- R7: Writing ones to 0x30 clears the latched edge raw bits in those positions. Zero bits leave the other raw bits set.
- R8: Masked status (0x28) equals raw AND NOT mask, and `irq` is the OR of the masked status.
- R9: A pin whose interrupt enable bit is 0 raises no new raw status.
- R10: A debounced pin's detected value changes only after two successive prescaler-tick samples agree. A pulse shorter than the tick period therefore raises no event.
- R11: While the prescale value is zero, a pin with debounce enabled raises no new raw status. Clearing that pin's debounce bit lets it detect again.
- R12: After reset, all registers, `pin_out`, `pin_oe`, raw status and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | PINS | Pad input levels |
| pin_out | output | PINS | Output data to pads |
| pin_oe | output | PINS | Output enable per pin |
| pin_pull_en | output | PINS | Pull resistor enable |
| pin_pull_up | output | PINS | Pull direction, 1 = up |
| pin_bypass | output | PINS | Bypass control bits |
| irq | output | 1 | OR of masked interrupt status |

## Verification
The assertions assume that `bus_wr` and `bus_addr` are never unknown while out of reset. They also assume that a clear write and the trigger-mode bits stay in place over the cycle in which a latched edge bit is checked. The stimulus meets this by driving every bus signal from a task at the falling edge to defined values. It also changes trigger, polarity and debounce settings only while the pins are quiet, and then writes the clear address before it drives new edges. Random pin patterns are held for several cycles so that every level reaches the status register before it is read.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_DOUT  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIN   = 8'h04;
  localparam logic [ADDR_W-1:0] A_OE    = 8'h08;
  localparam logic [ADDR_W-1:0] A_BYP   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] A_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] A_PEN   = 8'h18;
  localparam logic [ADDR_W-1:0] A_PTYP  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_IEN   = 8'h20;
  localparam logic [ADDR_W-1:0] A_RAW   = 8'h24;
  localparam logic [ADDR_W-1:0] A_MSKD  = 8'h28;
  localparam logic [ADDR_W-1:0] A_IMASK = 8'h2C;
  localparam logic [ADDR_W-1:0] A_ICLR  = 8'h30;
  localparam logic [ADDR_W-1:0] A_TRIG  = 8'h34;
  localparam logic [ADDR_W-1:0] A_BOTH  = 8'h38;
  localparam logic [ADDR_W-1:0] A_POL   = 8'h3C;
  localparam logic [ADDR_W-1:0] A_DBEN  = 8'h40;
  localparam logic [ADDR_W-1:0] A_PSC   = 8'h44;

  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
`timescale 1ns/1ps
module gpio_debounce #(
  parameter int W     = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic [PSC_W-1:0] psc,
  output logic [W-1:0]     filt,
  output logic             tick
);
  logic [PSC_W-1:0] cnt;
  logic [W-1:0]     last;
  logic             psc_zero;

  assign psc_zero = (psc == '0);
  assign tick     = !psc_zero && (cnt >= psc - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (psc_zero || tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // Per pin: take the new sample only where it matches the previous one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last <= '0;
      filt <= '0;
    end else if (tick) begin
      last <= din;
      filt <= (din & ~(din ^ last)) | (filt & (din ^ last));
    end
  end

  AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt)); // R10
  AST_NO_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psc_zero |=> $stable(filt)); // R11
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] det_in,
  input  logic [W-1:0] en,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] blocked,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw_q
);
  logic [W-1:0] prev;
  logic [W-1:0] live;
  logic [W-1:0] nxt;

  assign live = en & ~blocked;

  for (genvar gi = 0; gi < W; gi++) begin : g_pin
    logic rise, fall, edge_ev, lvl;
    assign rise    = det_in[gi] & ~prev[gi];
    assign fall    = ~det_in[gi] & prev[gi];
    assign edge_ev = both[gi] ? (rise | fall) : (pol[gi] ? fall : rise);
    assign lvl     = det_in[gi] ^ pol[gi];
    assign nxt[gi] = (trig[gi] == TRIG_LEVEL) ? (live[gi] & lvl)
                   : ((live[gi] & edge_ev) | (raw_q[gi] & ~clr[gi]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      raw_q <= '0;
    end else begin
      prev  <= det_in;
      raw_q <= nxt;
    end
  end

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~trig & ~clr) != '0) |=>
      (($past(raw_q & ~trig & ~clr) & ~trig & ~raw_q) == '0)); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((~en & ~raw_q) != '0) |=> (($past(~en & ~raw_q) & raw_q) == '0)); // R9
  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((blocked & ~raw_q) != '0) |=> (($past(blocked & ~raw_q) & raw_q) == '0)); // R11
endmodule

// File: rtl/gpio_bank_top.sv
`timescale 1ns/1ps
module gpio_bank_top
  import gpio_pkg::*;
#(
  parameter int PINS     = 32,
  parameter int PSC_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_pull_en,
  output logic [PINS-1:0]   pin_pull_up,
  output logic [PINS-1:0]   pin_bypass,
  output logic              irq
);
  logic [PINS-1:0]  dout_r, oe_r, byp_r, pen_r, ptyp_r;
  logic [PINS-1:0]  ien_r, imask_r, trig_r, both_r, pol_r, dben_r;
  logic [PSC_W-1:0] psc_r;
  logic [PINS-1:0]  wbits, clr_bits, sync_in, filt, det_in, blocked, raw, masked;
  logic             tick;

  assign wbits = bus_wdata[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_r <= '0; oe_r <= '0; byp_r <= '0; pen_r <= '0; ptyp_r <= '0;
      ien_r <= '0; imask_r <= '0; trig_r <= '0; both_r <= '0; pol_r <= '0;
      dben_r <= '0; psc_r <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DOUT:  dout_r  <= wbits;
        A_SET:   dout_r  <= dout_r | wbits;
        A_CLR:   dout_r  <= dout_r & ~wbits;
        A_OE:    oe_r    <= wbits;
        A_BYP:   byp_r   <= wbits;
        A_PEN:   pen_r   <= wbits;
        A_PTYP:  ptyp_r  <= wbits;
        A_IEN:   ien_r   <= wbits;
        A_IMASK: imask_r <= wbits;
        A_TRIG:  trig_r  <= wbits;
        A_BOTH:  both_r  <= wbits;
        A_POL:   pol_r   <= wbits;
        A_DBEN:  dben_r  <= wbits;
        A_PSC:   psc_r   <= bus_wdata[PSC_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_bits = (bus_wr && bus_addr == A_ICLR) ? wbits : '0;

  gpio_sync #(.W(PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in));

  gpio_debounce #(.W(PINS), .PSC_W(PSC_W)) u_dbnc (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .psc(psc_r),
    .filt(filt), .tick(tick));

  assign det_in  = (dben_r & filt) | (~dben_r & sync_in);
  assign blocked = dben_r & {PINS{psc_r == '0}};

  gpio_irq_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .det_in(det_in), .en(ien_r), .trig(trig_r),
    .both(both_r), .pol(pol_r), .blocked(blocked), .clr(clr_bits), .raw_q(raw));

  assign masked      = raw & ~imask_r;
  assign irq         = |masked;
  assign pin_out     = dout_r;
  assign pin_oe      = oe_r;
  assign pin_pull_en = pen_r;
  assign pin_pull_up = ptyp_r;
  assign pin_bypass  = byp_r;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DOUT:  bus_rdata = BUS_W'(dout_r);
      A_DIN:   bus_rdata = BUS_W'(sync_in);
      A_OE:    bus_rdata = BUS_W'(oe_r);
      A_BYP:   bus_rdata = BUS_W'(byp_r);
      A_PEN:   bus_rdata = BUS_W'(pen_r);
      A_PTYP:  bus_rdata = BUS_W'(ptyp_r);
      A_IEN:   bus_rdata = BUS_W'(ien_r);
      A_RAW:   bus_rdata = BUS_W'(raw);
      A_MSKD:  bus_rdata = BUS_W'(masked);
      A_IMASK: bus_rdata = BUS_W'(imask_r);
      A_TRIG:  bus_rdata = BUS_W'(trig_r);
      A_BOTH:  bus_rdata = BUS_W'(both_r);
      A_POL:   bus_rdata = BUS_W'(pol_r);
      A_DBEN:  bus_rdata = BUS_W'(dben_r);
      A_PSC:   bus_rdata = BUS_W'(psc_r);
      default: bus_rdata = '0;
    endcase
  end

  AST_SET_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((dout_r & $past(wbits)) == $past(wbits))); // R2
  AST_CLR_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((dout_r & $past(wbits)) == '0)); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((dout_r & ~$past(wbits)) == $past(dout_r & ~wbits))); // R2
endmodule

// File: tb/gpio_bank_top_tb.sv
`timescale 1ns/1ps
module gpio_bank_top_tb_top;
  import gpio_pkg::*;

  localparam int PINS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_pull_en, pin_pull_up, pin_bypass;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_top #(.PINS(PINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull_en(pin_pull_en),
    .pin_pull_up(pin_pull_up), .pin_bypass(pin_bypass), .irq(irq));

  function automatic logic [31:0] exp_level(logic [31:0] p, logic [31:0] pl, logic [31:0] en);
    return en & (p ^ pl);
  endfunction

  function automatic logic [31:0] exp_dout(logic [31:0] cur, int op, logic [31:0] v);
    case (op)
      0: return v;
      1: return cur | v;
      default: return cur & ~v;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pins(logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, mdl, pol, msk, pv;
    void'($urandom(32'd4021));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R12 reset state
    rd(A_DOUT, r); chk("R12 dout", r, 0);
    rd(A_RAW, r);  chk("R12 raw", r, 0);
    chk("R12 pin_oe", pin_oe, 0);
    chk("R12 irq", {31'd0, irq}, 0);

    // R1 storage and pad outputs
    wr(A_OE, 32'hDEADBEEF); rd(A_OE, r); chk("R1 oe", r, 32'hDEADBEEF);
    chk("R1 pin_oe", pin_oe, 32'hDEADBEEF);
    wr(A_BYP, 32'h0F0F1234); chk("R1 bypass", pin_bypass, 32'h0F0F1234);
    wr(A_PEN, 32'h8000_0001); chk("R1 pull_en", pin_pull_en, 32'h8000_0001);
    wr(A_PTYP, 32'h5555_AAAA); rd(A_PTYP, r); chk("R1 pull_type", r, 32'h5555_AAAA);
    chk("R1 pull_up", pin_pull_up, 32'h5555_AAAA);
    wr(A_PSC, 32'h0012_3456); rd(A_PSC, r); chk("R1 prescale 16b", r, 32'h0000_3456);
    wr(A_PSC, 32'h0);

    // R2 random set/clear/load against model
    mdl = 0;
    for (int i = 0; i < 30; i++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom % 3);
      v  = $urandom;
      wr(op == 0 ? A_DOUT : (op == 1 ? A_SET : A_CLR), v);
      mdl = exp_dout(mdl, op, v);
      rd(A_DOUT, r); chk("R2 dout", r, mdl);
      chk("R2 pin_out", pin_out, mdl);
    end
    wr(A_DOUT, 32'h0000_00F0); wr(A_SET, 32'h0000_0003); wr(A_CLR, 32'h0000_0010);
    chk("R2 directed", pin_out, 32'h0000_00E3);

    // R3 synchronized input
    pins(32'hA5A5_0F0F); idle(3);
    rd(A_DIN, r); chk("R3 data in", r, 32'hA5A5_0F0F);

    // R6 R8 level mode random
    wr(A_TRIG, 32'hFFFF_FFFF); wr(A_IEN, 32'hFFFF_FFFF);
    for (int i = 0; i < 30; i++) begin
      pol = $urandom; msk = $urandom; pv = $urandom;
      if (i == 0) msk = 32'hFFFF_FFFF;
      wr(A_POL, pol); wr(A_IMASK, msk); pins(pv); idle(4);
      rd(A_RAW, r);  chk("R6 level raw", r, exp_level(pv, pol, 32'hFFFF_FFFF));
      rd(A_MSKD, r); chk("R8 masked", r, exp_level(pv, pol, 32'hFFFF_FFFF) & ~msk);
      chk("R8 irq", {31'd0, irq}, {31'd0, |(exp_level(pv, pol, 32'hFFFF_FFFF) & ~msk)});
    end

    // R4 R5 R7 edge mode
    wr(A_IMASK, 0); pins(0);
    wr(A_TRIG, 0); wr(A_POL, 32'h0000_00F0); wr(A_BOTH, 32'h0000_0F00);
    wr(A_IEN, 32'h0000_FFFF);
    idle(4); wr(A_ICLR, 32'hFFFF_FFFF); idle(1);
    rd(A_RAW, r); chk("R7 clear all", r, 0);
    pins(32'h00FF_0FFF); idle(4);
    rd(A_RAW, r); chk("R4 R5 rising", r, 32'h0000_0F0F);
    pins(32'h00FF_0FFF); idle(2);
    rd(A_RAW, r); chk("R4 latched", r, 32'h0000_0F0F);
    wr(A_ICLR, 32'h0000_000F); idle(1);
    rd(A_RAW, r); chk("R7 partial clear", r, 32'h0000_0F00);
    pins(0); idle(4);
    rd(A_RAW, r); chk("R4 R5 falling", r, 32'h0000_0FF0);
    chk("R9 disabled pins 16..23 quiet", r & 32'h00FF_0000, 0);

    // R10 debounce with prescale 4 on pin 0, rising edge
    wr(A_IEN, 32'h1); wr(A_DBEN, 32'h1); wr(A_PSC, 32'h4); wr(A_POL, 0); wr(A_BOTH, 0);
    idle(20); wr(A_ICLR, 32'hFFFF_FFFF); idle(1);
    pins(32'h1); pins(32'h0); idle(20);
    rd(A_RAW, r); chk("R10 glitch ignored", r, 0);
    pins(32'h1); idle(3);
    rd(A_RAW, r); chk("R10 not yet settled", r, 0);
    idle(20);
    rd(A_RAW, r); chk("R10 debounced edge", r, 32'h1);

    // R11 prescale zero blocks debounced pin
    pins(0); wr(A_PSC, 0); wr(A_ICLR, 32'hFFFF_FFFF);
    wr(A_TRIG, 32'h2); wr(A_IEN, 32'h2); wr(A_DBEN, 32'h2);
    pins(32'h2); idle(10);
    rd(A_RAW, r); chk("R11 blocked", r, 0);
    wr(A_DBEN, 0); idle(2);
    rd(A_RAW, r); chk("R11 unblocked", r, 32'h2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule